// File: doc/BRIEF.md
# Windowed Pixel Transfer Engine

This block takes a stream of 16-bit words from one data port and places the pixels they carry into a rectangular window of a row-major frame buffer. The window corners, the input format code, the data source and the rotation select are register values held outside the block. The block reads them only when it arms a new transfer.

A transfer is armed by a strobe that marks a write to the source select. It is also armed by the first data word that arrives while no transfer is pending. Once armed, the block counts words until the window is full. Each time the bytes received complete a pixel, it emits one frame-buffer write address.

When the last word lands, the block commits the window. It pulses a done flag and widens a dirty bounding box that the display refresh logic reads. A refresh request returns that box to an inverted, empty state. Pixel format conversion and the rotated write itself are left to downstream logic. This block only reports which path the transfer uses.

Top module: `pix_window_engine`

## Requirements
- R1: After reset no transfer is pending, the pixel write strobe and done flag are low, and the dirty box is empty: min_x equals the panel width, min_y equals the panel height, max_x and max_y are 0, and dirty_valid is 0.
- R2: The 4-bit format code sets the input bytes per pixel. Code 1 gives 2 bytes. Codes 2 and 3 give 3 bytes. Codes 6 and 7 give 4 bytes. Every other code is unsupported, and a transfer cannot arm with it.
- R3: Arming is refused when the source select exceeds 3, when the format is unsupported, when the x end is below the x start, or when the y end is below the y start. A refused request leaves any pending transfer untouched.
- R4: A transfer takes (bytes_per_pixel × width × height) / 2 words, rounded down, where width = x_end − x_start + 1 and height = y_end − y_start + 1. The done flag is high for exactly one cycle, in the cycle after the edge that takes the final word, and the busy flag is low in that cycle.
- R5: A source-select strobe arms a fresh transfer and discards any partly received one. A data word that arrives with nothing pending first tries to arm with the current settings and then counts as the first word. If that arming fails, the word is dropped and no pixel write or done results.
- R6: Bytes from successive words accumulate. Each word whose bytes complete a pixel produces one pixel write strobe in the following cycle. Pixels are visited from x_start to x_end along a row, and then on the next row down.
- R7: The pixel write address equals (y × panel_width + x) × OUT_BPP, with OUT_BPP = 4 by default.
- R8: On commit the dirty box grows so that min_x ≤ x_start, min_y ≤ y_start, max_x ≥ x_end + 1 and max_y ≥ y_end + 1. The new box is visible in the cycle after the final word.
- R9: A refresh request resets the box to min_x = panel width, min_y = panel height and max_x = max_y = 0. dirty_valid is high only when max_x > min_x. If a refresh and a commit fall in the same cycle, the reset applies first and the committed window is then merged in.
- R10: The rotate flag is high when the 2-bit rotation select is nonzero. It is latched when the transfer arms and holds for the whole transfer.
- R11: If a source-select strobe and a data word arrive in the same cycle, the fresh transfer arms first and that word counts as its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_x0 | input | CW | Window x start |
| win_y0 | input | CW | Window y start |
| win_x1 | input | CW | Window x end (inclusive) |
| win_y1 | input | CW | Window y end (inclusive) |
| fmt_code | input | 4 | Input pixel format code |
| src_sel | input | 3 | Data source select |
| rot_sel | input | 2 | Rotation select |
| panel_w | input | CW+1 | Panel width in pixels |
| panel_h | input | CW+1 | Panel height in pixels |
| src_wr | input | 1 | Strobe for a write to the source select (arms a transfer) |
| data_wr | input | 1 | Data port word strobe |
| refresh | input | 1 | Display refresh done; resets the dirty box |
| pix_we | output | 1 | Pixel write strobe |
| pix_addr | output | 2*CW+2+clog2(OUT_BPP) | Frame-buffer byte address of the pixel |
| xfer_done | output | 1 | One-cycle commit pulse |
| xfer_busy | output | 1 | Transfer pending |
| xfer_rot | output | 1 | Rotated write path selected |
| dirty_min_x | output | CW+1 | Dirty box left edge |
| dirty_min_y | output | CW+1 | Dirty box top edge |
| dirty_max_x | output | CW+1 | Dirty box right edge (exclusive) |
| dirty_max_y | output | CW+1 | Dirty box bottom edge (exclusive) |
| dirty_valid | output | 1 | Box is non-empty |

## Verification
Every result is registered once. A pixel write, the done pulse, the busy and rotate flags and the updated dirty box all appear in the cycle that follows the rising edge that took the word, strobe or refresh. The bench changes inputs on falling edges and reads outputs on the next falling edge, which falls inside that cycle. Expected pixel addresses come from a byte-accumulation model of the requirements. They are queued before the words are sent, and a monitor matches them in order as write strobes appear. Refused arming is confirmed by watching for one more cycle that no write and no done follow, and that busy stays low.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

    localparam logic [2:0] SRC_LIMIT = 3'd3;

    // Input bytes per pixel for each format code; 0 marks an unsupported code.
    function automatic logic [2:0] fmt_to_bpp(input logic [3:0] code);
        case (code)
            4'd1:       return 3'd2;
            4'd2, 4'd3: return 3'd3;
            4'd6, 4'd7: return 3'd4;
            default:    return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/pwe_arm_calc.sv
module pwe_arm_calc #(
    parameter int CW = 10
) (
    input  logic [CW-1:0]     x0_i,
    input  logic [CW-1:0]     y0_i,
    input  logic [CW-1:0]     x1_i,
    input  logic [CW-1:0]     y1_i,
    input  logic [3:0]        fmt_i,
    input  logic [2:0]        src_i,
    output logic              ok_o,
    output logic [2:0]        bpp_o,
    output logic [2*CW+1:0]   words_o
);
    import pwe_pkg::*;

    localparam int WCW = 2*CW + 2;
    localparam int PW  = 2*CW + 5;

    logic [CW:0]   span_x, span_y;
    logic [PW-1:0] byte_total;

    always_comb begin
        bpp_o      = fmt_to_bpp(fmt_i);
        span_x     = {1'b0, x1_i} - {1'b0, x0_i} + 1'b1;
        span_y     = {1'b0, y1_i} - {1'b0, y0_i} + 1'b1;
        byte_total = PW'(bpp_o) * PW'(span_x) * PW'(span_y);
        words_o    = WCW'(byte_total >> 1);
        ok_o       = (src_i <= SRC_LIMIT) && (bpp_o != 3'd0)
                  && (x1_i >= x0_i) && (y1_i >= y0_i);
    end

endmodule

// File: rtl/pwe_walker.sv
module pwe_walker #(
    parameter int CW      = 10,
    parameter int OUT_BPP = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_wr_i,
    input  logic                   data_wr_i,
    input  logic                   arm_ok_i,
    input  logic [2:0]             arm_bpp_i,
    input  logic [2*CW+1:0]        arm_words_i,
    input  logic [CW-1:0]          x0_i,
    input  logic [CW-1:0]          y0_i,
    input  logic [CW-1:0]          x1_i,
    input  logic [CW-1:0]          y1_i,
    input  logic [1:0]             rot_sel_i,
    input  logic [CW:0]            panel_w_i,
    output logic                   pix_we_o,
    output logic [2*CW+1+$clog2(OUT_BPP):0] pix_addr_o,
    output logic                   done_o,
    output logic                   busy_o,
    output logic                   rot_o,
    output logic                   commit_o,
    output logic [CW-1:0]          cm_x0_o,
    output logic [CW-1:0]          cm_y0_o,
    output logic [CW:0]            cm_x1e_o,
    output logic [CW:0]            cm_y1e_o
);
    localparam int WCW = 2*CW + 2;
    localparam int AW  = 2*CW + 2 + $clog2(OUT_BPP);

    typedef struct packed {
        logic           active;
        logic [WCW-1:0] words;
        logic [CW-1:0]  cx;
        logic [CW-1:0]  cy;
        logic [CW-1:0]  x0;
        logic [CW-1:0]  x1;
        logic [CW-1:0]  y0;
        logic [CW-1:0]  y1;
        logic [2:0]     bpp;
        logic [2:0]     resid;
        logic           rot;
        logic           pix_we;
        logic [AW-1:0]  pix_addr;
        logic           done;
    } walk_t;

    walk_t cur_s, st_d, st_q;
    logic  arm_try, commit_s;
    logic [2:0]    byte_sum;
    logic [AW-1:0] lin_idx;

    always_comb begin
        cur_s        = st_q;
        cur_s.pix_we = 1'b0;
        cur_s.done   = 1'b0;
        commit_s     = 1'b0;
        byte_sum     = '0;
        lin_idx      = '0;

        // Arming stage: strobe always retries, a word retries only when idle.
        arm_try = src_wr_i || (data_wr_i && !st_q.active);
        if (arm_try && arm_ok_i) begin
            cur_s.active = 1'b1;
            cur_s.words  = arm_words_i;
            cur_s.cx     = x0_i;
            cur_s.cy     = y0_i;
            cur_s.x0     = x0_i;
            cur_s.x1     = x1_i;
            cur_s.y0     = y0_i;
            cur_s.y1     = y1_i;
            cur_s.bpp    = arm_bpp_i;
            cur_s.resid  = 3'd0;
            cur_s.rot    = |rot_sel_i;
        end

        // Word stage: accumulate bytes, emit a pixel when one is complete.
        st_d = cur_s;
        if (data_wr_i && cur_s.active) begin
            byte_sum = cur_s.resid + 3'd2;
            if (byte_sum >= cur_s.bpp) begin
                lin_idx       = AW'(cur_s.cy) * AW'(panel_w_i) + AW'(cur_s.cx);
                st_d.pix_we   = 1'b1;
                st_d.pix_addr = lin_idx * AW'(OUT_BPP);
                st_d.resid    = byte_sum - cur_s.bpp;
                if (cur_s.cx == cur_s.x1) begin
                    st_d.cx = cur_s.x0;
                    st_d.cy = cur_s.cy + 1'b1;
                end else begin
                    st_d.cx = cur_s.cx + 1'b1;
                end
            end else begin
                st_d.resid = byte_sum;
            end
            st_d.words = cur_s.words - 1'b1;
            if (cur_s.words == WCW'(1)) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
                commit_s    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_we_o   = st_q.pix_we;
    assign pix_addr_o = st_q.pix_addr;
    assign done_o     = st_q.done;
    assign busy_o     = st_q.active;
    assign rot_o      = st_q.rot;
    assign commit_o   = commit_s;
    assign cm_x0_o    = cur_s.x0;
    assign cm_y0_o    = cur_s.y0;
    assign cm_x1e_o   = {1'b0, cur_s.x1} + 1'b1;
    assign cm_y1e_o   = {1'b0, cur_s.y1} + 1'b1;

    // R4: a pending transfer always has words left to receive
    p_active_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.words != '0));

    // R6: the pixel cursor stays inside the window columns
    p_cursor_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cx >= st_q.x0 && st_q.cx <= st_q.x1));

    // R10: the rotate flag does not change while a transfer runs without re-arming
    p_rot_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !src_wr_i) |=> $stable(rot_o));

endmodule

// File: rtl/pwe_dirty_box.sv
module pwe_dirty_box #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW:0]   panel_w_i,
    input  logic [CW:0]   panel_h_i,
    input  logic          refresh_i,
    input  logic          commit_i,
    input  logic [CW-1:0] x0_i,
    input  logic [CW-1:0] y0_i,
    input  logic [CW:0]   x1e_i,
    input  logic [CW:0]   y1e_i,
    output logic [CW:0]   min_x_o,
    output logic [CW:0]   min_y_o,
    output logic [CW:0]   max_x_o,
    output logic [CW:0]   max_y_o,
    output logic          valid_o
);
    typedef struct packed {
        logic [CW:0] min_x;
        logic [CW:0] min_y;
        logic [CW:0] max_x;
        logic [CW:0] max_y;
    } box_t;

    box_t box_d, box_q, empty_s;

    always_comb begin
        empty_s = '{min_x: panel_w_i, min_y: panel_h_i, max_x: '0, max_y: '0};
        box_d   = box_q;
        if (refresh_i) begin
            box_d = empty_s;
        end
        if (commit_i) begin
            if ({1'b0, x0_i} < box_d.min_x) box_d.min_x = {1'b0, x0_i};
            if ({1'b0, y0_i} < box_d.min_y) box_d.min_y = {1'b0, y0_i};
            if (x1e_i > box_d.max_x)        box_d.max_x = x1e_i;
            if (y1e_i > box_d.max_y)        box_d.max_y = y1e_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            box_q <= '{min_x: panel_w_i, min_y: panel_h_i, max_x: '0, max_y: '0};
        end else begin
            box_q <= box_d;
        end
    end

    assign min_x_o = box_q.min_x;
    assign min_y_o = box_q.min_y;
    assign max_x_o = box_q.max_x;
    assign max_y_o = box_q.max_y;
    assign valid_o = box_q.max_x > box_q.min_x;

    // R8: after a commit the box covers the committed window
    p_commit_covered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (min_x_o <= {1'b0, $past(x0_i)} && min_y_o <= {1'b0, $past(y0_i)}
                      && max_x_o >= $past(x1e_i) && max_y_o >= $past(y1e_i)));

    // R9: a refresh with no commit leaves nothing to redraw
    p_refresh_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i && !commit_i) |=> (!valid_o && max_y_o == '0));

endmodule

// File: rtl/pix_window_engine.sv
module pix_window_engine #(
    parameter int CW      = 10,
    parameter int OUT_BPP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] win_x0,
    input  logic [CW-1:0] win_y0,
    input  logic [CW-1:0] win_x1,
    input  logic [CW-1:0] win_y1,
    input  logic [3:0]    fmt_code,
    input  logic [2:0]    src_sel,
    input  logic [1:0]    rot_sel,
    input  logic [CW:0]   panel_w,
    input  logic [CW:0]   panel_h,
    input  logic          src_wr,
    input  logic          data_wr,
    input  logic          refresh,
    output logic          pix_we,
    output logic [2*CW+1+$clog2(OUT_BPP):0] pix_addr,
    output logic          xfer_done,
    output logic          xfer_busy,
    output logic          xfer_rot,
    output logic [CW:0]   dirty_min_x,
    output logic [CW:0]   dirty_min_y,
    output logic [CW:0]   dirty_max_x,
    output logic [CW:0]   dirty_max_y,
    output logic          dirty_valid
);
    localparam int WCW = 2*CW + 2;

    logic           arm_ok;
    logic [2:0]     arm_bpp;
    logic [WCW-1:0] arm_words;
    logic           commit;
    logic [CW-1:0]  cm_x0, cm_y0;
    logic [CW:0]    cm_x1e, cm_y1e;

    pwe_arm_calc #(.CW(CW)) u_calc (
        .x0_i    (win_x0),
        .y0_i    (win_y0),
        .x1_i    (win_x1),
        .y1_i    (win_y1),
        .fmt_i   (fmt_code),
        .src_i   (src_sel),
        .ok_o    (arm_ok),
        .bpp_o   (arm_bpp),
        .words_o (arm_words)
    );

    pwe_walker #(.CW(CW), .OUT_BPP(OUT_BPP)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_wr_i    (src_wr),
        .data_wr_i   (data_wr),
        .arm_ok_i    (arm_ok),
        .arm_bpp_i   (arm_bpp),
        .arm_words_i (arm_words),
        .x0_i        (win_x0),
        .y0_i        (win_y0),
        .x1_i        (win_x1),
        .y1_i        (win_y1),
        .rot_sel_i   (rot_sel),
        .panel_w_i   (panel_w),
        .pix_we_o    (pix_we),
        .pix_addr_o  (pix_addr),
        .done_o      (xfer_done),
        .busy_o      (xfer_busy),
        .rot_o       (xfer_rot),
        .commit_o    (commit),
        .cm_x0_o     (cm_x0),
        .cm_y0_o     (cm_y0),
        .cm_x1e_o    (cm_x1e),
        .cm_y1e_o    (cm_y1e)
    );

    pwe_dirty_box #(.CW(CW)) u_box (
        .clk       (clk),
        .rst_n     (rst_n),
        .panel_w_i (panel_w),
        .panel_h_i (panel_h),
        .refresh_i (refresh),
        .commit_i  (commit),
        .x0_i      (cm_x0),
        .y0_i      (cm_y0),
        .x1e_i     (cm_x1e),
        .y1e_i     (cm_y1e),
        .min_x_o   (dirty_min_x),
        .min_y_o   (dirty_min_y),
        .max_x_o   (dirty_max_x),
        .max_y_o   (dirty_max_y),
        .valid_o   (dirty_valid)
    );

    // R5: a word refused at arming produces neither a write nor a commit
    p_refused_word_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !src_wr && !xfer_busy && !arm_ok) |=> (!pix_we && !xfer_done));

    // R4: the commit pulse coincides with the end of the pending state
    p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !xfer_busy);

    // R3: a refused strobe from idle leaves the block idle
    p_refused_arm_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && !arm_ok && !xfer_busy && !data_wr) |=> !xfer_busy);

endmodule

// File: tb/pix_window_engine_bench.sv
module pix_window_engine_bench;

    localparam int PW = 16;
    localparam int PH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  win_x0 = '0, win_y0 = '0, win_x1 = '0, win_y1 = '0;
    logic [3:0]  fmt_code = 4'd1;
    logic [2:0]  src_sel = '0;
    logic [1:0]  rot_sel = '0;
    logic [10:0] panel_w = 11'(PW);
    logic [10:0] panel_h = 11'(PH);
    logic        src_wr = 1'b0, data_wr = 1'b0, refresh = 1'b0;
    logic        pix_we, xfer_done, xfer_busy, xfer_rot, dirty_valid;
    logic [23:0] pix_addr;
    logic [10:0] dirty_min_x, dirty_min_y, dirty_max_x, dirty_max_y;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    pix_window_engine u_pix_window_engine (
        .clk(clk), .rst_n(rst_n),
        .win_x0(win_x0), .win_y0(win_y0), .win_x1(win_x1), .win_y1(win_y1),
        .fmt_code(fmt_code), .src_sel(src_sel), .rot_sel(rot_sel),
        .panel_w(panel_w), .panel_h(panel_h),
        .src_wr(src_wr), .data_wr(data_wr), .refresh(refresh),
        .pix_we(pix_we), .pix_addr(pix_addr), .xfer_done(xfer_done),
        .xfer_busy(xfer_busy), .xfer_rot(xfer_rot),
        .dirty_min_x(dirty_min_x), .dirty_min_y(dirty_min_y),
        .dirty_max_x(dirty_max_x), .dirty_max_y(dirty_max_y),
        .dirty_valid(dirty_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Monitor: every pixel write must match the head of the expected queue (R6, R7)
    always @(negedge clk) begin
        if (rst_n && pix_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected pixel write", int'(pix_addr), -1);
            end else begin
                chk_eq("R7 pixel address", int'(pix_addr), exp_q.pop_front());
            end
        end
    end

    function automatic int bpp_of(input int code);
        case (code)
            1: return 2;
            2, 3: return 3;
            6, 7: return 4;
            default: return 0;
        endcase
    endfunction

    // Driver side of the scoreboard: queue the addresses a full transfer produces
    task automatic expect_xfer(input int x0, input int y0, input int x1, input int y1,
                               input int code);
        int b = bpp_of(code);
        int nw = b * (x1 - x0 + 1) * (y1 - y0 + 1) / 2;
        int acc = 0;
        int x = x0;
        int y = y0;
        for (int i = 0; i < nw; i++) begin
            acc += 2;
            if (acc >= b) begin
                exp_q.push_back((y * PW + x) * 4);
                acc -= b;
                if (x == x1) begin x = x0; y++; end else x++;
            end
        end
    endtask

    task automatic set_win(input int x0, input int y0, input int x1, input int y1,
                           input int code, input int src, input int rot);
        win_x0 = 10'(x0); win_y0 = 10'(y0); win_x1 = 10'(x1); win_y1 = 10'(y1);
        fmt_code = 4'(code); src_sel = 3'(src); rot_sel = 2'(rot);
    endtask

    task automatic pulse_src;
        src_wr = 1'b1;
        @(negedge clk);
        src_wr = 1'b0;
    endtask

    task automatic send_word(input bit last, input string req);
        data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
        chk_eq(req, int'(xfer_done), int'(last));
    endtask

    task automatic send_words(input int n, input string req);
        for (int i = 0; i < n; i++) send_word(i == n - 1, req);
        chk_eq({req, " busy clear at done"}, int'(xfer_busy), 0);
        @(negedge clk);
        chk_eq({req, " done single cycle"}, int'(xfer_done), 0);
        chk_eq({req, " scoreboard drained"}, exp_q.size(), 0);
    endtask

    task automatic chk_box(input string req, input int mnx, input int mny,
                           input int mxx, input int mxy);
        chk_eq({req, " min_x"}, int'(dirty_min_x), mnx);
        chk_eq({req, " min_y"}, int'(dirty_min_y), mny);
        chk_eq({req, " max_x"}, int'(dirty_max_x), mxx);
        chk_eq({req, " max_y"}, int'(dirty_max_y), mxy);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_eq("R1 pix_we", int'(pix_we), 0);
        chk_eq("R1 done", int'(xfer_done), 0);
        chk_eq("R1 busy", int'(xfer_busy), 0);
        chk_eq("R1 dirty_valid", int'(dirty_valid), 0);
        chk_box("R1 box", PW, PH, 0, 0);

        // R2 R4 R6 R7 R8: 2-byte format, 3x2 window armed by strobe
        set_win(2, 1, 4, 2, 1, 0, 0);
        pulse_src();
        chk_eq("R5 busy after strobe", int'(xfer_busy), 1);
        expect_xfer(2, 1, 4, 2, 1);
        send_words(6, "R4 six words fmt1");
        chk_box("R8 first merge", 2, 1, 5, 3);
        chk_eq("R9 valid after commit", int'(dirty_valid), 1);

        // R5 R2: 3-byte format armed by the first data word, 2x1 window -> 3 words
        set_win(0, 0, 1, 0, 3, 1, 0);
        expect_xfer(0, 0, 1, 0, 3);
        send_words(3, "R5 arm by word fmt3");
        chk_box("R8 second merge", 0, 0, 5, 3);

        // R10 R2: 4-byte format, single pixel at (10,5), rotated
        set_win(10, 5, 10, 5, 7, 3, 2);
        pulse_src();
        chk_eq("R10 rotate latched", int'(xfer_rot), 1);
        rot_sel = 2'd0;
        expect_xfer(10, 5, 10, 5, 7);
        send_word(1'b0, "R4 fmt7 first word");
        chk_eq("R10 rotate held", int'(xfer_rot), 1);
        send_words(1, "R4 fmt7 last word");
        chk_box("R8 third merge", 0, 0, 11, 6);

        // R2 R3 R5: refused arming and dropped words
        set_win(0, 0, 0, 0, 4, 0, 0);
        pulse_src();
        chk_eq("R2 unsupported code 4 refused", int'(xfer_busy), 0);
        send_word(1'b0, "R5 dropped word no done");
        chk_eq("R5 dropped word no write", int'(pix_we), 0);
        chk_eq("R5 dropped word idle", int'(xfer_busy), 0);
        set_win(0, 0, 0, 0, 1, 5, 0);
        pulse_src();
        chk_eq("R3 source above 3 refused", int'(xfer_busy), 0);
        set_win(3, 0, 2, 0, 1, 0, 0);
        pulse_src();
        chk_eq("R3 x end below start refused", int'(xfer_busy), 0);
        set_win(0, 4, 0, 3, 1, 0, 0);
        send_word(1'b0, "R3 y end below start word dropped");
        chk_eq("R3 y end below start idle", int'(xfer_busy), 0);

        // R3: a refused strobe does not disturb a pending transfer
        set_win(0, 0, 1, 0, 1, 0, 0);
        pulse_src();
        set_win(0, 0, 0, 0, 5, 0, 0);
        pulse_src();
        chk_eq("R3 pending transfer kept", int'(xfer_busy), 1);
        expect_xfer(0, 0, 1, 0, 1);
        send_words(2, "R3 pending completes");

        // R9: refresh empties the box
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
        chk_box("R9 refresh", PW, PH, 0, 0);
        chk_eq("R9 valid after refresh", int'(dirty_valid), 0);

        // R9 R11: refresh, strobe and word in one cycle, 1-word window at (3,2)
        set_win(0, 0, 0, 0, 1, 0, 0);
        expect_xfer(0, 0, 0, 0, 1);
        send_words(1, "R4 one word window");
        set_win(3, 2, 3, 2, 1, 0, 0);
        expect_xfer(3, 2, 3, 2, 1);
        refresh = 1'b1;
        src_wr = 1'b1;
        data_wr = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
        src_wr = 1'b0;
        data_wr = 1'b0;
        chk_eq("R11 same cycle arm and word done", int'(xfer_done), 1);
        chk_box("R9 refresh before merge", 3, 2, 4, 3);
        @(negedge clk);
        chk_eq("R11 scoreboard drained", exp_q.size(), 0);

        // R4: 3-byte single pixel -> 1 word, no complete pixel, still commits
        set_win(1, 1, 1, 1, 2, 0, 0);
        send_words(1, "R4 truncated count fmt2");

        // R5: strobe mid-transfer restarts with the new window
        set_win(0, 0, 1, 0, 1, 0, 0);
        pulse_src();
        exp_q.push_back(0);
        send_word(1'b0, "R5 partial first transfer");
        set_win(5, 0, 5, 0, 1, 0, 0);
        pulse_src();
        expect_xfer(5, 0, 5, 0, 1);
        send_words(1, "R5 restarted transfer");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule